// File: doc/BRIEF.md
# Snooping Invalidate Cache-Line Controller

This block keeps the coherence state of every line in a small direct-mapped cache. The cache sits on one atomic bus that it shares with other caches. Each line is Invalid, Shared or Exclusive. The processor side sends read and write requests and gets back a hit, the read data, or a stall. On a miss the block asks for the bus. Once the bus is granted, it writes back a dirty victim if there is one, then issues the fill operation and installs the line. The processor holds its request until it sees a hit, so a miss always finishes with a retry that hits.

The snoop side watches operations that other agents place on the bus. When another cache misses on a line held Exclusive here, the block supplies the dirty data in the same cycle. A remote read miss then downgrades the line to Shared, and a remote write miss invalidates it. A snoop and a processor request in the same cycle are resolved in favour of the snoop. Line data is kept in a plain register array. Memory, the arbiter and the other caches are outside the block.

Top module: `snoop_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first processor read misses (cpu_hit_o low, cpu_stall_o high).
- R2: A read request whose tag matches a Shared or Exclusive line hits in the same cycle and returns the stored word, with no bus request.
- R3: A write request hits only when its tag matches an Exclusive line; a write to a Shared or Invalid line is a miss and stalls.
- R4: A read miss issues a bus read (bus_op_o = 1) at the request address and installs the returned word as Shared.
- R5: A write miss, including a write to a matching Shared line, issues a bus write-miss (bus_op_o = 2) and installs the line as Exclusive; the processor's retry then writes its data.
- R6: If the indexed line is Exclusive with a different tag when the bus is granted, a write-back (bus_op_o = 3) carrying the victim's address and data completes before the fill operation.
- R7: A snooped read miss (snp_write_i = 0) that matches an Exclusive line raises snp_flush_o with the line's data in that cycle and leaves the line Shared.
- R8: A snooped write miss (snp_write_i = 1) that matches a valid line invalidates it, and flushes the data first if the line was Exclusive.
- R9: A snoop whose tag differs from the stored tag, or whose line is Invalid, changes no state and raises no flush.
- R10: In a cycle with snp_valid_i high, a processor request does not hit and is stalled.
- R11: bus_req_o rises the cycle after a miss, stays high through the write-back and fill, and drops the cycle after the fill is acknowledged. Bus operations (bus_op_o nonzero) appear only after bus_gnt_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request valid, held until hit |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address of the request |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_hit_o | output | 1 | Request completes this cycle |
| cpu_stall_o | output | 1 | Request pending and not completed |
| cpu_rdata_o | output | DATA_W | Read data, valid with a read hit |
| bus_req_o | output | 1 | Bus ownership request |
| bus_gnt_i | input | 1 | Bus granted to this cache |
| bus_op_o | output | 2 | 0 none, 1 read miss, 2 write miss, 3 write-back |
| bus_addr_o | output | ADDR_W | Address of the current bus operation |
| bus_wdata_o | output | DATA_W | Write-back data |
| bus_rdata_i | input | DATA_W | Fill data from memory |
| bus_ack_i | input | 1 | Current bus operation completes this cycle |
| snp_valid_i | input | 1 | Another agent's miss is on the bus |
| snp_write_i | input | 1 | Snooped miss is a write miss |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_flush_o | output | 1 | Dirty line supplied for the snooped miss |
| snp_flush_data_o | output | DATA_W | Data of the flushed line |

## Verification
The bench uses only four tags on three indexes. This forces frequent conflicts where an Exclusive victim must be written back. A design that skips that write-back, or sends it after the fill, loses the dirty word, and later reads return stale memory. Snoops land on the very lines being fetched, including during arbitration, so the write-back decision must use the state at grant time. A design that latches it at miss time writes back a line a snoop has already given up. Writes to Shared lines and snoops with mismatched tags are frequent. A design that treats the first as a hit misses the bus write, and one that ignores the tag invalidates lines it should keep. Snoops also coincide with processor requests, which exposes any hit let through without priority.

// File: rtl/scc_pkg.sv
package scc_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHD = 2'd1,
    LS_EXC = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BOP_NONE = 2'd0,
    BOP_READ = 2'd1,
    BOP_RFO  = 2'd2,
    BOP_WB   = 2'd3
  } bus_op_e;

  typedef enum logic [1:0] {
    C_IDLE,
    C_ARB,
    C_WB,
    C_FILL
  } ctl_st_e;
endpackage

// File: rtl/scc_lines.sv
module scc_lines
  import scc_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  a_idx_i,
  output line_st_e          a_st_o,
  output logic [TAG_W-1:0]  a_tag_o,
  output logic [DATA_W-1:0] a_data_o,
  input  logic [IDX_W-1:0]  b_idx_i,
  output line_st_e          b_st_o,
  output logic [TAG_W-1:0]  b_tag_o,
  output logic [DATA_W-1:0] b_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  line_st_e          wr_st_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              st_en_i,
  input  logic [IDX_W-1:0]  st_idx_i,
  input  line_st_e          st_val_i
);
  localparam int LINES = 1 << IDX_W;

  line_st_e          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]   <= LS_INV;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      // snoop update first; a fill or write to the same line wins
      if (st_en_i) st_q[st_idx_i] <= st_val_i;
      if (wr_en_i) begin
        st_q[wr_idx_i]   <= wr_st_i;
        tag_q[wr_idx_i]  <= wr_tag_i;
        data_q[wr_idx_i] <= wr_data_i;
      end
    end
  end

  assign a_st_o   = st_q[a_idx_i];
  assign a_tag_o  = tag_q[a_idx_i];
  assign a_data_o = data_q[a_idx_i];
  assign b_st_o   = st_q[b_idx_i];
  assign b_tag_o  = tag_q[b_idx_i];
  assign b_data_o = data_q[b_idx_i];
endmodule

// File: rtl/scc_snoop.sv
module scc_snoop
  import scc_pkg::*;
#(
  parameter int TAG_W  = 9,
  parameter int DATA_W = 32
) (
  input  logic              snp_valid_i,
  input  logic              snp_write_i,
  input  logic [TAG_W-1:0]  snp_tag_i,
  input  line_st_e          line_st_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              flush_o,
  output logic [DATA_W-1:0] flush_data_o,
  output logic              upd_en_o,
  output line_st_e          upd_st_o
);
  logic present;

  assign present      = snp_valid_i && (line_st_i != LS_INV) && (line_tag_i == snp_tag_i);
  assign flush_o      = present && (line_st_i == LS_EXC);
  assign flush_data_o = flush_o ? line_data_i : '0;

  always_comb begin
    upd_en_o = 1'b0;
    upd_st_o = line_st_i;
    if (present) begin
      if (snp_write_i) begin
        upd_en_o = 1'b1;
        upd_st_o = LS_INV;
      end else if (line_st_i == LS_EXC) begin
        upd_en_o = 1'b1;
        upd_st_o = LS_SHD;
      end
    end
  end
endmodule

// File: rtl/scc_ctrl.sv
module scc_ctrl
  import scc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              snp_valid_i,
  input  logic              bus_gnt_i,
  input  logic              bus_ack_i,
  input  line_st_e          line_st_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  output logic              cpu_hit_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] hold_addr_o,
  output logic              hold_we_o,
  output logic              bus_req_o,
  output bus_op_e           bus_op_o,
  output logic              fill_done_o
);
  ctl_st_e           st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic              tag_eq, can_hit, miss;
  logic [TAG_W-1:0]  cpu_tag, hold_tag;

  assign cpu_tag  = cpu_addr_i[ADDR_W-1:IDX_W];
  assign hold_tag = addr_q[ADDR_W-1:IDX_W];
  assign tag_eq   = (line_tag_i == (busy_o ? hold_tag : cpu_tag));
  assign can_hit  = tag_eq && (cpu_we_i ? (line_st_i == LS_EXC) : (line_st_i != LS_INV));

  assign busy_o      = (st_q != C_IDLE);
  assign cpu_hit_o   = cpu_req_i && !busy_o && !snp_valid_i && can_hit;
  assign miss        = cpu_req_i && !busy_o && !snp_valid_i && !can_hit;
  assign bus_req_o   = busy_o;
  assign hold_addr_o = addr_q;
  assign hold_we_o   = we_q;
  assign fill_done_o = (st_q == C_FILL) && bus_ack_i;

  always_comb begin
    unique case (st_q)
      C_WB:    bus_op_o = BOP_WB;
      C_FILL:  bus_op_o = we_q ? BOP_RFO : BOP_READ;
      default: bus_op_o = BOP_NONE;
    endcase
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      C_IDLE: if (miss) st_d = C_ARB;
      // victim decision taken at grant: snoops may change the line while waiting
      C_ARB:  if (bus_gnt_i) st_d = (line_st_i == LS_EXC && !tag_eq) ? C_WB : C_FILL;
      C_WB:   if (bus_ack_i) st_d = C_FILL;
      C_FILL: if (bus_ack_i) st_d = C_IDLE;
      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= C_IDLE;
      addr_q <= '0;
      we_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (miss) begin
        addr_q <= cpu_addr_i;
        we_q   <= cpu_we_i;
      end
    end
  end
endmodule

// File: rtl/snoop_cache_ctrl.sv
module snoop_cache_ctrl
  import scc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_hit_o,
  output logic              cpu_stall_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [1:0]        bus_op_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_ack_i,
  input  logic              snp_valid_i,
  input  logic              snp_write_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_flush_o,
  output logic [DATA_W-1:0] snp_flush_data_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  a_idx, b_idx;
  line_st_e          a_st, b_st, wr_st, upd_st;
  logic [TAG_W-1:0]  a_tag, b_tag, wr_tag;
  logic [DATA_W-1:0] a_data, b_data, wr_data;
  logic              wr_en, upd_en, cpu_hit, busy, hold_we, fill_done;
  logic [ADDR_W-1:0] hold_addr;
  bus_op_e           op;

  assign a_idx = busy ? hold_addr[IDX_W-1:0] : cpu_addr_i[IDX_W-1:0];
  assign b_idx = snp_addr_i[IDX_W-1:0];

  scc_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_req_i   (cpu_req_i),
    .cpu_we_i    (cpu_we_i),
    .cpu_addr_i  (cpu_addr_i),
    .snp_valid_i (snp_valid_i),
    .bus_gnt_i   (bus_gnt_i),
    .bus_ack_i   (bus_ack_i),
    .line_st_i   (a_st),
    .line_tag_i  (a_tag),
    .cpu_hit_o   (cpu_hit),
    .busy_o      (busy),
    .hold_addr_o (hold_addr),
    .hold_we_o   (hold_we),
    .bus_req_o   (bus_req_o),
    .bus_op_o    (op),
    .fill_done_o (fill_done)
  );

  scc_snoop #(.TAG_W(TAG_W), .DATA_W(DATA_W)) i_snoop (
    .snp_valid_i  (snp_valid_i),
    .snp_write_i  (snp_write_i),
    .snp_tag_i    (snp_addr_i[ADDR_W-1:IDX_W]),
    .line_st_i    (b_st),
    .line_tag_i   (b_tag),
    .line_data_i  (b_data),
    .flush_o      (snp_flush_o),
    .flush_data_o (snp_flush_data_o),
    .upd_en_o     (upd_en),
    .upd_st_o     (upd_st)
  );

  assign wr_en   = (cpu_hit && cpu_we_i) || fill_done;
  assign wr_tag  = fill_done ? hold_addr[ADDR_W-1:IDX_W] : a_tag;
  assign wr_st   = fill_done ? (hold_we ? LS_EXC : LS_SHD) : LS_EXC;
  assign wr_data = fill_done ? bus_rdata_i : cpu_wdata_i;

  scc_lines #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_lines (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_idx_i   (a_idx),
    .a_st_o    (a_st),
    .a_tag_o   (a_tag),
    .a_data_o  (a_data),
    .b_idx_i   (b_idx),
    .b_st_o    (b_st),
    .b_tag_o   (b_tag),
    .b_data_o  (b_data),
    .wr_en_i   (wr_en),
    .wr_idx_i  (a_idx),
    .wr_tag_i  (wr_tag),
    .wr_st_i   (wr_st),
    .wr_data_i (wr_data),
    .st_en_i   (upd_en),
    .st_idx_i  (b_idx),
    .st_val_i  (upd_st)
  );

  assign cpu_hit_o   = cpu_hit;
  assign cpu_stall_o = cpu_req_i && !cpu_hit;
  assign cpu_rdata_o = cpu_hit ? a_data : '0;
  assign bus_op_o    = op;
  assign bus_wdata_o = (op == BOP_WB) ? a_data : '0;

  always_comb begin
    unique case (op)
      BOP_WB:            bus_addr_o = {a_tag, hold_addr[IDX_W-1:0]};
      BOP_READ, BOP_RFO: bus_addr_o = hold_addr;
      default:           bus_addr_o = '0;
    endcase
  end
endmodule

// File: rtl/scc_checker.sv
module scc_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_hit_o,
  input logic              cpu_stall_o,
  input logic              bus_req_o,
  input logic              bus_gnt_i,
  input logic [1:0]        bus_op_o,
  input logic              bus_ack_i,
  input logic              snp_valid_i,
  input logic              snp_flush_o
);
  a_r10_snoop_blocks_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i |-> !cpu_hit_o);

  a_r9_flush_needs_snoop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_flush_o |-> snp_valid_i);

  a_r2_hit_no_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_hit_o |-> (!bus_req_o && !cpu_stall_o));

  a_r11_op_needs_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_op_o != 2'd0) |-> (bus_req_o && bus_gnt_i));

  a_r11_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !(bus_ack_i && (bus_op_o == 2'd1 || bus_op_o == 2'd2))) |=> bus_req_o);

  a_r4_fill_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_ack_i && (bus_op_o == 2'd1 || bus_op_o == 2'd2)) |=> !bus_req_o);

  a_r6_wb_before_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_ack_i && bus_op_o == 2'd3) |=> (bus_op_o == 2'd1 || bus_op_o == 2'd2));

  a_r11_req_from_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) |-> $past(cpu_req_i && !cpu_hit_o));
endmodule

bind snoop_cache_ctrl scc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_scc_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_req_i   (cpu_req_i),
  .cpu_hit_o   (cpu_hit_o),
  .cpu_stall_o (cpu_stall_o),
  .bus_req_o   (bus_req_o),
  .bus_gnt_i   (bus_gnt_i),
  .bus_op_o    (bus_op_o),
  .bus_ack_i   (bus_ack_i),
  .snp_valid_i (snp_valid_i),
  .snp_flush_o (snp_flush_o)
);

// File: tb/test_snoop_cache_ctrl.sv
module test_snoop_cache_ctrl;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = 3;
  localparam int DATA_W = 32;
  localparam int LINES  = 1 << IDX_W;
  localparam int NCYC   = 6000;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cpu_req_i = 1'b0, cpu_we_i = 1'b0;
  logic [ADDR_W-1:0] cpu_addr_i = '0;
  logic [DATA_W-1:0] cpu_wdata_i = '0;
  logic              cpu_hit_o, cpu_stall_o;
  logic [DATA_W-1:0] cpu_rdata_o;
  logic              bus_req_o;
  logic              bus_gnt_i = 1'b0;
  logic [1:0]        bus_op_o;
  logic [ADDR_W-1:0] bus_addr_o;
  logic [DATA_W-1:0] bus_wdata_o;
  logic [DATA_W-1:0] bus_rdata_i = '0;
  logic              bus_ack_i = 1'b0;
  logic              snp_valid_i = 1'b0, snp_write_i = 1'b0;
  logic [ADDR_W-1:0] snp_addr_i = '0;
  logic              snp_flush_o;
  logic [DATA_W-1:0] snp_flush_data_o;

  always #10 clk = ~clk;

  snoop_cache_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) i_snoop_cache_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i), .cpu_addr_i(cpu_addr_i), .cpu_wdata_i(cpu_wdata_i),
    .cpu_hit_o(cpu_hit_o), .cpu_stall_o(cpu_stall_o), .cpu_rdata_o(cpu_rdata_o),
    .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i), .bus_op_o(bus_op_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i), .bus_ack_i(bus_ack_i),
    .snp_valid_i(snp_valid_i), .snp_write_i(snp_write_i), .snp_addr_i(snp_addr_i),
    .snp_flush_o(snp_flush_o), .snp_flush_data_o(snp_flush_data_o)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // reference model: 0 invalid, 1 shared, 2 exclusive
  int                m_st   [LINES];
  int                m_tag  [LINES];
  logic [DATA_W-1:0] m_data [LINES];
  logic [DATA_W-1:0] mem [int];
  bit                m_busy = 1'b0;
  int                m_phase = 0; // 0 arb, 1 write-back, 2 fill

  function automatic logic [DATA_W-1:0] mem_rd(int a);
    if (mem.exists(a)) return mem[a];
    return 32'h5A00_0000 ^ (a * 32'h0001_0003);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  function automatic int pick_addr();
    int t = 1 + ($urandom % 4);
    int x = $urandom % 3;
    return (t << IDX_W) | x;
  endfunction

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    bit have_req = 1'b0;
    bit gnt_prev = 1'b0;
    bit ack_en;
    for (int i = 0; i < LINES; i++) begin
      m_st[i] = 0; m_tag[i] = 0; m_data[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      int  ci, si, ctag, stag;
      bit  exp_hit, s_match, exp_flush, s_v, s_w, c_req, c_we, s_hit, c_gnt, c_ack;
      logic [DATA_W-1:0] s_flush_d, c_rdata;
      string htag, stg;
      @(negedge clk);
      if (cyc == 0) begin
        have_req = 1'b1; cpu_we_i = 1'b0; cpu_addr_i = ADDR_W'((1 << IDX_W) | 1);
      end else if (!have_req && ($urandom % 2 == 0)) begin
        have_req    = 1'b1;
        cpu_we_i    = ($urandom % 5) < 2;
        cpu_addr_i  = ADDR_W'(pick_addr());
        cpu_wdata_i = $urandom;
      end
      cpu_req_i = have_req;
      if (!gnt_prev && cyc > 0 && ($urandom % 4 == 0)) begin
        snp_valid_i = 1'b1;
        snp_write_i = $urandom % 2;
        snp_addr_i  = ADDR_W'(($urandom % 8 == 0) ? ((5 << IDX_W) | ($urandom % 3)) : pick_addr());
      end else begin
        snp_valid_i = 1'b0;
      end
      bus_gnt_i = bus_req_o && !snp_valid_i;
      gnt_prev  = bus_gnt_i;
      ack_en    = ($urandom % 3) != 0;
      #1;
      bus_ack_i   = ack_en && (bus_op_o != 2'd0);
      bus_rdata_i = mem_rd(int'(bus_addr_o));
      #1;

      ci   = int'(cpu_addr_i) % LINES;
      ctag = int'(cpu_addr_i) >> IDX_W;
      si   = int'(snp_addr_i) % LINES;
      stag = int'(snp_addr_i) >> IDX_W;
      s_v = snp_valid_i; s_w = snp_write_i; c_req = cpu_req_i; c_we = cpu_we_i;
      exp_hit = c_req && !s_v && !m_busy && m_tag[ci] == ctag &&
                (c_we ? m_st[ci] == 2 : m_st[ci] != 0);
      htag = (cyc == 0) ? "R1" : (c_req && s_v) ? "R10" : c_we ? "R3" : "R2";
      chk(cpu_hit_o == exp_hit, htag, "cpu_hit_o", 32'(cpu_hit_o), 32'(exp_hit));
      chk(cpu_stall_o == (c_req && !exp_hit), htag, "cpu_stall_o", 32'(cpu_stall_o), 32'(c_req && !exp_hit));
      if (exp_hit && !c_we)
        chk(cpu_rdata_o == m_data[ci], "R2", "cpu_rdata_o", cpu_rdata_o, m_data[ci]);

      s_match   = s_v && m_st[si] != 0 && m_tag[si] == stag;
      exp_flush = s_match && m_st[si] == 2;
      stg = !s_match ? "R9" : s_w ? "R8" : "R7";
      if (s_v) begin
        chk(snp_flush_o == exp_flush, stg, "snp_flush_o", 32'(snp_flush_o), 32'(exp_flush));
        if (exp_flush)
          chk(snp_flush_data_o == m_data[si], stg, "snp_flush_data_o", snp_flush_data_o, m_data[si]);
      end

      chk(bus_req_o == m_busy, "R11", "bus_req_o", 32'(bus_req_o), 32'(m_busy));
      if (!m_busy || m_phase == 0) begin
        chk(bus_op_o == 2'd0, "R11", "bus_op_o idle", 32'(bus_op_o), 32'd0);
      end else if (m_phase == 1) begin
        chk(bus_op_o == 2'd3, "R6", "bus_op_o", 32'(bus_op_o), 32'd3);
        chk(int'(bus_addr_o) == ((m_tag[ci] << IDX_W) | ci), "R6", "victim addr",
            32'(bus_addr_o), 32'((m_tag[ci] << IDX_W) | ci));
        chk(bus_wdata_o == m_data[ci], "R6", "victim data", bus_wdata_o, m_data[ci]);
      end else begin
        chk(bus_op_o == (c_we ? 2'd2 : 2'd1), c_we ? "R5" : "R4", "bus_op_o", 32'(bus_op_o), c_we ? 32'd2 : 32'd1);
        chk(bus_addr_o == cpu_addr_i, c_we ? "R5" : "R4", "fill addr", 32'(bus_addr_o), 32'(cpu_addr_i));
      end

      s_hit = cpu_hit_o; c_gnt = bus_gnt_i; c_ack = bus_ack_i; c_rdata = bus_rdata_i;
      s_flush_d = m_data[si];
      @(posedge clk);
      if (s_match) begin
        if (m_st[si] == 2) mem[(stag << IDX_W) | si] = s_flush_d;
        if (s_w) m_st[si] = 0;
        else if (m_st[si] == 2) m_st[si] = 1;
      end
      if (exp_hit && c_we) m_data[ci] = cpu_wdata_i;
      if (s_hit) have_req = 1'b0;
      if (!m_busy) begin
        if (c_req && !s_v && !exp_hit) begin
          m_busy = 1'b1; m_phase = 0;
        end
      end else begin
        case (m_phase)
          0: if (c_gnt) m_phase = (m_st[ci] == 2 && m_tag[ci] != ctag) ? 1 : 2;
          1: if (c_ack) begin
               mem[(m_tag[ci] << IDX_W) | ci] = m_data[ci];
               m_phase = 2;
             end
          default: if (c_ack) begin
               m_tag[ci] = ctag; m_st[ci] = c_we ? 2 : 1; m_data[ci] = c_rdata;
               m_busy = 1'b0;
             end
        endcase
      end
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule